// File: doc/BRIEF.md
# Octal DTR Mode Switch Sequencer

This block sits on the controller side of a serial NOR flash link. It moves the attached device from single-line extended SPI operation into 8D-8D-8D octal double-transfer-rate operation, and back again. A pulse on `start` launches the sequence. The level of `enter_octal` at that moment picks the direction. The block then issues a fixed series of memory operations, one at a time, through a generic operation request port. Each request carries an opcode, an address byte count and value, a dummy cycle count, a data byte count, write data and a protocol select. The block waits for each operation to complete before it issues the next one.

Entering octal mode sets the array-read dummy count first and waits for the device to become ready. It then writes the mode register. Leaving octal mode writes the mode register together with the dummy register in one two-byte transfer, because one-byte transfers are not legal in octal DTR. In both directions the block then reads the device identification in the new protocol and compares it with an expected value. It finishes with a one-cycle `done` pulse and a two-bit result code.

Top module: `octdtr_switch_seq`

## Requirements
- R1: On an entry request, the first operation is write-enable (opcode 0x06, single-line, no address, no data). The second is a register write: opcode 0x81, single-line, 3 address bytes, address 0x000001, one data byte of 0x14 (decimal 20).
- R2: After the dummy-register write, the block issues status reads (opcode 0x05, single-line, read of 1 byte, no address, no dummy). It reissues the status read while bit 0 of the returned byte (cpl_rdata[0]) is 1, and moves on once that bit is 0.
- R3: After the status read returns ready, the block issues a second write-enable in single-line mode. It then issues opcode 0x81 in single-line mode with 3 address bytes, address 0x000000 and one data byte of 0xE7.
- R4: On an exit request, the block issues write-enable in octal DTR mode. It then issues opcode 0x81 in octal DTR mode with 4 address bytes, address 0x00000000 and two data bytes: 0xFF first (op_wdata[7:0]) and 0x1F second (op_wdata[15:8]). No status read is issued.
- R5: The last operation is the ID read: opcode 0x9F, no address, read. After entry it uses octal DTR with 8 dummy cycles. After exit it uses single-line with 0 dummy cycles. The byte count is ID_LEN rounded up to an even number (4 for the default ID_LEN of 3).
- R6: op_proto is 1 for octal DTR and 0 for single-line. op_cmd_repeat (opcode byte sent twice) is 1 exactly when op_proto is 1. Fields an operation does not use (address, dummy, write data, byte count) are driven to zero.
- R7: Only the first ID_LEN bytes of the ID read data are compared, byte i being cpl_rdata[8i+7:8i] against expected_id[8i+7:8i]. A mismatch gives result 2. Differences in the padding bytes are ignored.
- R8: A completion with cpl_err set ends the sequence at once with result 1. No further operation is issued.
- R9: If poll_limit consecutive status reads report busy, the sequence ends with result 3 and no further operation. A limit of 0 behaves as 1.
- R10: op_valid stays high with an unchanged request until op_ready is sampled high. At most one operation is outstanding, and completions are taken only after acceptance.
- R11: busy is high from the cycle after an accepted start until the sequence ends. done is a single-cycle pulse with busy low. result holds 0 for success until the next start. A start while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a mode switch when idle |
| enter_octal | input | 1 | 1 = switch into octal DTR, 0 = switch back to single-line |
| poll_limit | input | TMO_W | Number of busy status reads allowed |
| expected_id | input | 8*ID_LEN | Expected ID bytes, byte 0 in bits 7:0 |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| result | output | 2 | 0 ok, 1 operation error, 2 ID mismatch, 3 ready timeout |
| op_valid | output | 1 | Operation request valid |
| op_ready | input | 1 | Operation request accepted |
| op_opcode | output | 8 | Command opcode |
| op_proto | output | 1 | 0 single-line, 1 octal DTR |
| op_cmd_repeat | output | 1 | Send opcode byte twice |
| op_addr_bytes | output | 3 | Address byte count |
| op_addr | output | 32 | Address value |
| op_dummy | output | 5 | Dummy cycle count |
| op_is_read | output | 1 | Data phase direction, 1 = read |
| op_nbytes | output | NB_W | Data byte count |
| op_wdata | output | 16 | Write data, first byte in bits 7:0 |
| cpl_valid | input | 1 | Operation completion |
| cpl_err | input | 1 | Completion reports failure |
| cpl_rdata | input | 8*RD_BYTES | Read data, byte 0 in bits 7:0 |

## Verification
The embedded properties assume that the operation port follows the handshake. A completion arrives only for an operation that has been accepted, and only one at a time. `start` is also assumed to be a clean synchronous level. The bench responder keeps to this: it raises `op_ready` only while `op_valid` is high, drops it after one accepted cycle, and raises `cpl_valid` for exactly one cycle a fixed latency later. The stray start pulses it sends during a run fall in the waiting state, so the ignore rule is exercised without breaking these assumptions.

// File: rtl/octsw_pkg.sv
package octsw_pkg;

    localparam logic [7:0]  OPC_WREN   = 8'h06;
    localparam logic [7:0]  OPC_WRREG  = 8'h81;
    localparam logic [7:0]  OPC_RDSR   = 8'h05;
    localparam logic [7:0]  OPC_RDID   = 8'h9F;

    localparam logic [7:0]  VAL_DUMMY20  = 8'd20;
    localparam logic [7:0]  VAL_OCTAL    = 8'hE7;
    localparam logic [7:0]  VAL_SPI      = 8'hFF;
    localparam logic [7:0]  VAL_DUMMYDEF = 8'h1F;

    localparam logic [31:0] REG_MODE   = 32'h0000_0000;
    localparam logic [31:0] REG_DUMMY  = 32'h0000_0001;
    localparam logic [4:0]  ID_DUMMY_OCT = 5'd8;

    typedef enum logic {
        PROTO_1S = 1'b0,
        PROTO_8D = 1'b1
    } proto_e;

    typedef enum logic [1:0] {
        RES_OK    = 2'd0,
        RES_OPERR = 2'd1,
        RES_IDBAD = 2'd2,
        RES_TMO   = 2'd3
    } result_e;

    typedef enum logic [3:0] {
        ST_EN_WREN,
        ST_EN_DUMMY,
        ST_EN_POLL,
        ST_EN_WREN2,
        ST_EN_MODE,
        ST_EN_ID,
        ST_DIS_WREN,
        ST_DIS_MODE,
        ST_DIS_ID
    } step_e;

    typedef struct packed {
        logic [7:0]  opcode;
        proto_e      proto;
        logic        cmd_rep;
        logic [2:0]  addr_bytes;
        logic [31:0] addr;
        logic [4:0]  dummy;
        logic        is_read;
        logic [7:0]  nbytes;
        logic [15:0] wdata;
    } op_req_t;

    function automatic step_e step_after(step_e s);
        case (s)
            ST_EN_WREN:  return ST_EN_DUMMY;
            ST_EN_DUMMY: return ST_EN_POLL;
            ST_EN_POLL:  return ST_EN_WREN2;
            ST_EN_WREN2: return ST_EN_MODE;
            ST_EN_MODE:  return ST_EN_ID;
            ST_DIS_WREN: return ST_DIS_MODE;
            ST_DIS_MODE: return ST_DIS_ID;
            default:     return s;
        endcase
    endfunction

    function automatic logic is_id_step(step_e s);
        return (s == ST_EN_ID) || (s == ST_DIS_ID);
    endfunction

endpackage

// File: rtl/octsw_step_rom.sv
module octsw_step_rom
    import octsw_pkg::*;
#(
    parameter int RD_BYTES = 4
) (
    input  step_e   step,
    output op_req_t req
);

    localparam logic [7:0] ID_NB = 8'(RD_BYTES);

    always_comb begin
        req = '0;
        case (step)
            ST_EN_WREN, ST_EN_WREN2: begin
                req.opcode = OPC_WREN;
                req.proto  = PROTO_1S;
            end
            ST_EN_DUMMY: begin
                req.opcode     = OPC_WRREG;
                req.proto      = PROTO_1S;
                req.addr_bytes = 3'd3;
                req.addr       = REG_DUMMY;
                req.nbytes     = 8'd1;
                req.wdata      = {8'h00, VAL_DUMMY20};
            end
            ST_EN_POLL: begin
                req.opcode  = OPC_RDSR;
                req.proto   = PROTO_1S;
                req.is_read = 1'b1;
                req.nbytes  = 8'd1;
            end
            ST_EN_MODE: begin
                req.opcode     = OPC_WRREG;
                req.proto      = PROTO_1S;
                req.addr_bytes = 3'd3;
                req.addr       = REG_MODE;
                req.nbytes     = 8'd1;
                req.wdata      = {8'h00, VAL_OCTAL};
            end
            ST_EN_ID: begin
                req.opcode  = OPC_RDID;
                req.proto   = PROTO_8D;
                req.cmd_rep = 1'b1;
                req.dummy   = ID_DUMMY_OCT;
                req.is_read = 1'b1;
                req.nbytes  = ID_NB;
            end
            ST_DIS_WREN: begin
                req.opcode  = OPC_WREN;
                req.proto   = PROTO_8D;
                req.cmd_rep = 1'b1;
            end
            ST_DIS_MODE: begin
                req.opcode     = OPC_WRREG;
                req.proto      = PROTO_8D;
                req.cmd_rep    = 1'b1;
                req.addr_bytes = 3'd4;
                req.addr       = REG_MODE;
                req.nbytes     = 8'd2;
                req.wdata      = {VAL_DUMMYDEF, VAL_SPI};
            end
            ST_DIS_ID: begin
                req.opcode  = OPC_RDID;
                req.proto   = PROTO_1S;
                req.is_read = 1'b1;
                req.nbytes  = ID_NB;
            end
            default: req = '0;
        endcase
    end

    // R6: octal transfers always carry the doubled opcode, single-line never
    always_comb begin
        a_rep_proto_r6: assert ((req.proto == PROTO_8D) == req.cmd_rep);
    end

endmodule

// File: rtl/octsw_poll_timer.sv
module octsw_poll_timer #(
    parameter int TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             busy_seen,
    input  logic [TMO_W-1:0] limit,
    output logic             expired
);

    logic [TMO_W-1:0] cnt_q;
    logic [TMO_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + 1'b1;
    assign expired  = busy_seen && (cnt_next >= {1'b0, limit});

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (busy_seen && !expired) begin
            cnt_q <= cnt_next[TMO_W-1:0];
        end
    end

    // R9: the count of busy reads never passes the limit
    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        (limit != '0) |-> (cnt_q < limit));

endmodule

// File: rtl/octsw_id_cmp.sv
module octsw_id_cmp #(
    parameter int ID_LEN   = 3,
    parameter int RD_BYTES = 4
) (
    input  logic [RD_BYTES*8-1:0] rdata,
    input  logic [ID_LEN*8-1:0]   expected,
    output logic                  match
);

    logic [ID_LEN-1:0] byte_ok;

    for (genvar i = 0; i < ID_LEN; i++) begin : g_byte
        assign byte_ok[i] = (rdata[8*i +: 8] == expected[8*i +: 8]);
    end

    assign match = &byte_ok;

endmodule

// File: rtl/octdtr_switch_seq.sv
module octdtr_switch_seq
    import octsw_pkg::*;
#(
    parameter  int ID_LEN   = 3,
    parameter  int TMO_W    = 16,
    localparam int RD_BYTES = ((ID_LEN + 1) / 2) * 2,
    localparam int NB_W     = $clog2(RD_BYTES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic                  enter_octal,
    input  logic [TMO_W-1:0]      poll_limit,
    input  logic [ID_LEN*8-1:0]   expected_id,
    output logic                  busy,
    output logic                  done,
    output logic [1:0]            result,
    output logic                  op_valid,
    input  logic                  op_ready,
    output logic [7:0]            op_opcode,
    output logic                  op_proto,
    output logic                  op_cmd_repeat,
    output logic [2:0]            op_addr_bytes,
    output logic [31:0]           op_addr,
    output logic [4:0]            op_dummy,
    output logic                  op_is_read,
    output logic [NB_W-1:0]       op_nbytes,
    output logic [15:0]           op_wdata,
    input  logic                  cpl_valid,
    input  logic                  cpl_err,
    input  logic [RD_BYTES*8-1:0] cpl_rdata
);

    typedef enum logic [1:0] {
        F_IDLE,
        F_ISSUE,
        F_WAIT
    } fsm_e;

    fsm_e    fsm_q;
    step_e   step_q;
    logic    done_q;
    result_e res_q;
    op_req_t req;
    logic    id_match;
    logic    poll_busy;
    logic    tmo_hit;
    logic    cpl_take;
    logic    launch;

    octsw_step_rom #(.RD_BYTES(RD_BYTES)) rom_i (
        .step (step_q),
        .req  (req)
    );

    octsw_id_cmp #(.ID_LEN(ID_LEN), .RD_BYTES(RD_BYTES)) cmp_i (
        .rdata    (cpl_rdata),
        .expected (expected_id),
        .match    (id_match)
    );

    assign launch    = (fsm_q == F_IDLE) && start;
    assign cpl_take  = (fsm_q == F_WAIT) && cpl_valid;
    assign poll_busy = cpl_take && !cpl_err && (step_q == ST_EN_POLL) && cpl_rdata[0];

    octsw_poll_timer #(.TMO_W(TMO_W)) tmr_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (launch),
        .busy_seen (poll_busy),
        .limit     (poll_limit),
        .expired   (tmo_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q  <= F_IDLE;
            step_q <= ST_EN_WREN;
            done_q <= 1'b0;
            res_q  <= RES_OK;
        end else begin
            done_q <= 1'b0;
            case (fsm_q)
                F_IDLE: begin
                    if (start) begin
                        step_q <= enter_octal ? ST_EN_WREN : ST_DIS_WREN;
                        res_q  <= RES_OK;
                        fsm_q  <= F_ISSUE;
                    end
                end
                F_ISSUE: begin
                    if (op_ready) begin
                        fsm_q <= F_WAIT;
                    end
                end
                F_WAIT: begin
                    if (cpl_valid) begin
                        if (cpl_err) begin
                            res_q  <= RES_OPERR;
                            done_q <= 1'b1;
                            fsm_q  <= F_IDLE;
                        end else if (poll_busy) begin
                            if (tmo_hit) begin
                                res_q  <= RES_TMO;
                                done_q <= 1'b1;
                                fsm_q  <= F_IDLE;
                            end else begin
                                fsm_q <= F_ISSUE;
                            end
                        end else if (is_id_step(step_q)) begin
                            res_q  <= id_match ? RES_OK : RES_IDBAD;
                            done_q <= 1'b1;
                            fsm_q  <= F_IDLE;
                        end else begin
                            step_q <= step_after(step_q);
                            fsm_q  <= F_ISSUE;
                        end
                    end
                end
                default: fsm_q <= F_IDLE;
            endcase
        end
    end

    assign busy          = (fsm_q != F_IDLE);
    assign done          = done_q;
    assign result        = res_q;
    assign op_valid      = (fsm_q == F_ISSUE);
    assign op_opcode     = req.opcode;
    assign op_proto      = req.proto;
    assign op_cmd_repeat = req.cmd_rep;
    assign op_addr_bytes = req.addr_bytes;
    assign op_addr       = req.addr;
    assign op_dummy      = req.dummy;
    assign op_is_read    = req.is_read;
    assign op_nbytes     = req.nbytes[NB_W-1:0];
    assign op_wdata      = req.wdata;

    // R10: a pending request keeps its content until accepted
    p_hold_req_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_ready) |=> (op_valid && $stable(op_opcode) &&
            $stable(op_addr) && $stable(op_wdata) && $stable(op_proto)));

    // R10: an accepted request is not followed by another one in the next cycle
    p_one_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_ready) |=> !op_valid);

    // R11: done lasts a single cycle and comes with busy low
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    p_done_idle_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R8: an erroring completion ends the run with the operation-error code
    p_err_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (cpl_take && cpl_err) |=> (done && result == RES_OPERR && !op_valid));

    // R9: a timeout result only follows a busy status read
    p_tmo_src_r9: assert property (@(posedge clk) disable iff (rst)
        (done && result == RES_TMO) |-> $past(poll_busy));

    // R5: the ID read asks for an even byte count
    p_id_even_r5: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_opcode == OPC_RDID) |-> (op_nbytes[0] == 1'b0));

endmodule

// File: tb/octdtr_switch_seq_tb_top.sv
module octdtr_switch_seq_tb_top;

    localparam int ID_LEN = 3;
    localparam int TMO_W  = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        enter_octal = 1'b0;
    logic [15:0] poll_limit = 16'd8;
    logic [23:0] expected_id = 24'h1A5B2C;
    logic        busy, done;
    logic [1:0]  result;
    logic        op_valid;
    logic        op_ready = 1'b0;
    logic [7:0]  op_opcode;
    logic        op_proto, op_cmd_repeat;
    logic [2:0]  op_addr_bytes;
    logic [31:0] op_addr;
    logic [4:0]  op_dummy;
    logic        op_is_read;
    logic [2:0]  op_nbytes;
    logic [15:0] op_wdata;
    logic        cpl_valid = 1'b0;
    logic        cpl_err = 1'b0;
    logic [31:0] cpl_rdata = '0;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    octdtr_switch_seq #(.ID_LEN(ID_LEN), .TMO_W(TMO_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .enter_octal(enter_octal),
        .poll_limit(poll_limit), .expected_id(expected_id),
        .busy(busy), .done(done), .result(result),
        .op_valid(op_valid), .op_ready(op_ready), .op_opcode(op_opcode),
        .op_proto(op_proto), .op_cmd_repeat(op_cmd_repeat),
        .op_addr_bytes(op_addr_bytes), .op_addr(op_addr), .op_dummy(op_dummy),
        .op_is_read(op_is_read), .op_nbytes(op_nbytes), .op_wdata(op_wdata),
        .cpl_valid(cpl_valid), .cpl_err(cpl_err), .cpl_rdata(cpl_rdata)
    );

    typedef struct packed {
        logic        en;
        logic [3:0]  polls;
        logic [3:0]  lim;
        logic [3:0]  err_at;
        logic [31:0] idv;
        logic [1:0]  res;
        logic [3:0]  nops;
        logic [1:0]  rdy_wait;
        logic        again;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 4'd0, 4'd8, 4'd15, 32'h001A5B2C, 2'd0, 4'd6,  2'd0, 1'b0},
        '{1'b0, 4'd0, 4'd8, 4'd15, 32'h001A5B2C, 2'd0, 4'd3,  2'd1, 1'b0},
        '{1'b1, 4'd3, 4'd8, 4'd15, 32'h001A5B2C, 2'd0, 4'd9,  2'd2, 1'b1},
        '{1'b1, 4'd5, 4'd5, 4'd15, 32'h001A5B2C, 2'd3, 4'd7,  2'd0, 1'b0},
        '{1'b1, 4'd0, 4'd8, 4'd1,  32'h001A5B2C, 2'd1, 4'd2,  2'd1, 1'b0},
        '{1'b0, 4'd0, 4'd8, 4'd2,  32'h001A5B2C, 2'd1, 4'd3,  2'd0, 1'b0},
        '{1'b1, 4'd0, 4'd8, 4'd15, 32'hFF1A5B2C, 2'd0, 4'd6,  2'd0, 1'b0},
        '{1'b0, 4'd0, 4'd8, 4'd15, 32'h001A5C2C, 2'd2, 4'd3,  2'd0, 1'b1},
        '{1'b1, 4'd2, 4'd8, 4'd3,  32'h001A5B2C, 2'd1, 4'd4,  2'd0, 1'b0},
        '{1'b1, 4'd4, 4'd5, 4'd15, 32'h001A5B2C, 2'd0, 4'd10, 2'd1, 1'b0}
    };

    // descriptor layout: opcode, proto, repeat, addr bytes, addr, dummy, read, nbytes, wdata
    localparam logic [69:0] D_WREN_1S = {8'h06, 1'b0, 1'b0, 3'd0, 32'd0, 5'd0, 1'b0, 3'd0, 16'h0000};
    localparam logic [69:0] D_DUMMY   = {8'h81, 1'b0, 1'b0, 3'd3, 32'd1, 5'd0, 1'b0, 3'd1, 16'h0014};
    localparam logic [69:0] D_POLL    = {8'h05, 1'b0, 1'b0, 3'd0, 32'd0, 5'd0, 1'b1, 3'd1, 16'h0000};
    localparam logic [69:0] D_MODE8   = {8'h81, 1'b0, 1'b0, 3'd3, 32'd0, 5'd0, 1'b0, 3'd1, 16'h00E7};
    localparam logic [69:0] D_ID_8D   = {8'h9F, 1'b1, 1'b1, 3'd0, 32'd0, 5'd8, 1'b1, 3'd4, 16'h0000};
    localparam logic [69:0] D_WREN_8D = {8'h06, 1'b1, 1'b1, 3'd0, 32'd0, 5'd0, 1'b0, 3'd0, 16'h0000};
    localparam logic [69:0] D_MODE1   = {8'h81, 1'b1, 1'b1, 3'd4, 32'd0, 5'd0, 1'b0, 3'd2, 16'h1FFF};
    localparam logic [69:0] D_ID_1S   = {8'h9F, 1'b0, 1'b0, 3'd0, 32'd0, 5'd0, 1'b1, 3'd4, 16'h0000};

    function automatic logic [69:0] exp_desc(logic en, int k, int p);
        if (en) begin
            if (k == 0) return D_WREN_1S;
            if (k == 1) return D_DUMMY;
            if (k < 3 + p) return D_POLL;
            if (k == 3 + p) return D_WREN_1S;
            if (k == 4 + p) return D_MODE8;
            return D_ID_8D;
        end
        if (k == 0) return D_WREN_8D;
        if (k == 1) return D_MODE1;
        return D_ID_1S;
    endfunction

    function automatic string tag_of(logic en, int k, int p);
        if (!en) return (k < 2) ? "R4" : "R5";
        if (k < 2) return "R1";
        if (k < 3 + p) return "R2";
        if (k < 5 + p) return "R3";
        return "R5";
    endfunction

    function automatic logic [69:0] act_desc();
        return {op_opcode, op_proto, op_cmd_repeat, op_addr_bytes, op_addr,
                op_dummy, op_is_read, op_nbytes, op_wdata};
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [69:0] act, input logic [69:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic run_case(input int idx, input vec_t v);
        int k = 0;
        int guard = 0;
        logic [69:0] d;
        enter_octal = v.en;
        poll_limit  = {12'd0, v.lim};
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R11", $sformatf("v%0d busy after start", idx), 70'(busy), 70'd1);
        while (!done && guard < 2000) begin
            guard++;
            if (op_valid) begin
                d = act_desc();
                if (k < int'(v.nops))
                    check(d == exp_desc(v.en, k, int'(v.polls)), tag_of(v.en, k, int'(v.polls)),
                          $sformatf("v%0d op%0d fields", idx, k), d, exp_desc(v.en, k, int'(v.polls)));
                else
                    check(1'b0, "R8", $sformatf("v%0d extra op%0d", idx, k), d, 70'd0);
                check(op_cmd_repeat == op_proto, "R6", $sformatf("v%0d op%0d repeat", idx, k),
                      70'(op_cmd_repeat), 70'(op_proto));
                for (int w = 0; w < int'(v.rdy_wait); w++) begin
                    @(negedge clk);
                    check(op_valid && act_desc() == d, "R10", $sformatf("v%0d op%0d held", idx, k),
                          act_desc(), d);
                end
                op_ready = 1'b1;
                @(negedge clk);
                op_ready = 1'b0;
                if (v.again) begin
                    start = 1'b1;
                    @(negedge clk);
                    start = 1'b0;
                end else begin
                    @(negedge clk);
                end
                cpl_valid = 1'b1;
                cpl_err   = (k == int'(v.err_at));
                if (d[69:62] == 8'h05)
                    cpl_rdata = {31'd0, ((k - 2) < int'(v.polls))};
                else if (d[69:62] == 8'h9F)
                    cpl_rdata = v.idv;
                else
                    cpl_rdata = '0;
                @(negedge clk);
                cpl_valid = 1'b0;
                cpl_err   = 1'b0;
                k++;
            end else begin
                @(negedge clk);
            end
        end
        check(done == 1'b1, "R11", $sformatf("v%0d done seen", idx), 70'(done), 70'd1);
        check(result == v.res, "R7 R8 R9 R11", $sformatf("v%0d result", idx),
              70'(result), 70'(v.res));
        check(k == int'(v.nops), "R8 R9", $sformatf("v%0d op count", idx), 70'(k), 70'(v.nops));
        @(negedge clk);
        check(!done && !busy && !op_valid, "R11", $sformatf("v%0d done single pulse", idx),
              {67'd0, done, busy, op_valid}, 70'd0);
        check(result == v.res, "R11", $sformatf("v%0d result held", idx), 70'(result), 70'(v.res));
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !op_valid && result == 2'd0, "R11", "reset state",
              {66'd0, busy, done, op_valid, |result}, 70'd0);

        for (int i = 0; i < NV; i++) begin
            run_case(i, VECS[i]);
        end

        // R9: a limit of zero acts as one busy read
        run_case(20, '{1'b1, 4'd3, 4'd0, 4'd15, 32'h001A5B2C, 2'd3, 4'd3, 2'd0, 1'b0});

        // R11: reset in the middle of a run returns to idle with no request
        enter_octal = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !op_valid && !done, "R11", "reset mid run",
              {67'd0, busy, op_valid, done}, 70'd0);

        // R5: after recovery an exit run still completes normally
        run_case(21, VECS[1]);

        finish_run();
    end

endmodule